// File: doc/BRIEF.md
# Strap-selected configuration loader

After reset, this block fills a serial configuration chain and presents its contents as parallel clock-generator settings. These are a feedback divider, a reference divider, an output range code, a cascade flag, a differential-reference flag, a bypass flag and an optional deskew-disable flag. It can load the chain from one of three sources. The first is an internal eight-entry table, addressed by three pins that act as straps during reset. The second is an external master that clocks the bits in directly. The third is an EEPROM reader, a separate block that this one starts and then accepts bits from.

A decoded two-bit strap selects the source. The block samples it on the last clock edge at which the synchronous active-low reset is still asserted. Every source moves bits through the same chain in the same order. The parallel outputs change only once, when the chain is full. In that same cycle a one-cycle completion pulse is raised. A new reset clears everything and a fresh load is needed.

Top module: `cfg_strap_loader`

## Requirements
- R1: While `rst_n` is low, every field output, `cfg_done` and `ee_start` are 0 at the next clock edge.
- R2: The source is taken from `strap_mode` at the last clock edge with `rst_n` low: 2'b00 and 2'b11 select the table, 2'b01 selects direct shifting, and 2'b10 selects the EEPROM reader. Changes to `strap_mode` after reset have no effect.
- R3: The chain holds, from the serial input end, the feedback divider bits 0 to 6, then range bits 0 and 1, then the deskew-disable bit if `WITH_DDSK` is 1, then the cascade flag, the differential flag, the bypass flag, and reference divider bits 0 to 5. The first bit received ends in reference divider bit 5 and the last ends in feedback divider bit 0. With the default `WITH_DDSK`=0, `deskew_off` reads 0.
- R4: In table mode, `{sel_msb, ser_clk, ser_dat}` sampled during reset form the code. Codes 0 to 3 have differential=1, and codes 4 to 7 have differential=0. The (cascade, range, ref_div, fb_div) values are: 0:(1,01,0,0) 1:(1,10,5,2) 2:(1,01,2,5) 3:(0,01,0,0) 4:(0,01,0,0) 5:(0,10,5,2) 6:(0,01,2,5). Code 7 has bypass=1 and every other field 0. Codes 0 to 6 have bypass=0.
- R5: In table mode, one bit is shifted per clock, and `cfg_done` is first high in the 20th cycle after the first cycle with `rst_n` high, for the default chain of 18 bits.
- R6: In direct mode, each of the first 18 rising edges of `ser_clk` (after a two-flop synchronizer) shifts in `ser_dat`. Further edges change nothing.
- R7: In EEPROM mode, `ee_start` is high for exactly the first cycle after reset release, and only in that mode. Each cycle with `ee_bit_vld` high shifts `ee_bit` in, up to 18 bits. Later bits are ignored.
- R8: The field outputs stay 0 until the last bit arrives. They then update together with a single one-cycle `cfg_done` pulse and stay stable until the next reset.
- R9: A reset asserted after, or in the middle of, a load clears the outputs and any partly shifted bits. The following load starts from an empty chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_mode | input | 2 | Decoded source strap |
| sel_msb | input | 1 | Table code bit 2 strap |
| ser_clk | input | 1 | Direct-mode serial clock; table code bit 1 strap |
| ser_dat | input | 1 | Direct-mode serial data; table code bit 0 strap |
| ee_bit_vld | input | 1 | EEPROM reader bit strobe |
| ee_bit | input | 1 | EEPROM reader bit |
| ee_start | output | 1 | Pulse that starts the EEPROM reader |
| fb_div | output | 7 | Feedback divider field |
| out_range | output | 2 | Output range field |
| ref_cascade | output | 1 | Reference comes from another loader's output |
| ref_diff | output | 1 | Differential reference input selected |
| pll_bypass | output | 1 | Bypass/test flag |
| ref_div | output | 6 | Reference divider field |
| deskew_off | output | 1 | Deskew disable field (0 when absent) |
| cfg_done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `ser_clk` and `ser_dat` are stable for at least three core cycles around each serial edge. They also assume that the strap pins are steady for several cycles before reset is released, so that the synchronizer sees no false edge at release. The stimulus holds the serial clock high and low for three cycles each and changes data only while the clock is low. It also keeps the straps fixed through five reset cycles. EEPROM bits are offered one cycle at a time with idle gaps.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int MAXW = 19;

  typedef enum logic [1:0] {
    SRC_ROM    = 2'b00,
    SRC_DIRECT = 2'b01,
    SRC_EEPROM = 2'b10,
    SRC_ROM2   = 2'b11
  } src_e;

  typedef struct packed {
    logic [5:0] m;
    logic       test;
    logic       cs;
    logic       cm;
    logic       ddsk;
    logic [1:0] r;
    logic [6:0] n;
  } cfg_fields_t;

  function automatic cfg_fields_t rom_entry(input logic [2:0] code);
    cfg_fields_t f;
    f = '0;
    f.cs = ~code[2];
    case (code)
      3'd0: begin f.cm = 1'b1; f.r = 2'b01; end
      3'd1: begin f.cm = 1'b1; f.r = 2'b10; f.m = 6'd5; f.n = 7'd2; end
      3'd2: begin f.cm = 1'b1; f.r = 2'b01; f.m = 6'd2; f.n = 7'd5; end
      3'd3: f.r = 2'b01;
      3'd4: f.r = 2'b01;
      3'd5: begin f.r = 2'b10; f.m = 6'd5; f.n = 7'd2; end
      3'd6: begin f.r = 2'b01; f.m = 6'd2; f.n = 7'd5; end
      default: f.test = 1'b1;
    endcase
    return f;
  endfunction

  // chain image, bit 0 = serial input end
  function automatic logic [MAXW-1:0] pack_chain(input cfg_fields_t f, input bit with_ddsk);
    if (with_ddsk) return {f.m, f.test, f.cs, f.cm, f.ddsk, f.r, f.n};
    else           return {1'b0, f.m, f.test, f.cs, f.cm, f.r, f.n};
  endfunction

  function automatic cfg_fields_t unpack_chain(input logic [MAXW-1:0] w, input bit with_ddsk);
    cfg_fields_t f;
    f.n = w[6:0];
    f.r = w[8:7];
    if (with_ddsk) begin
      f.ddsk = w[9];
      f.cm = w[10]; f.cs = w[11]; f.test = w[12]; f.m = w[18:13];
    end else begin
      f.ddsk = w[18] & 1'b0;
      f.cm = w[9]; f.cs = w[10]; f.test = w[11]; f.m = w[17:12];
    end
    return f;
  endfunction
endpackage

// File: rtl/cfg_rom.sv
module cfg_rom
  import cfg_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter bit DDSK_EN = 1'b0,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic [AW-1:0]   addr,
  output logic [MAXW-1:0] word_q
);
  logic [MAXW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign mem[g] = pack_chain(rom_entry(3'(g)), DDSK_EN);
  end

  always_ff @(posedge clk) begin
    word_q <= mem[addr];
  end
endmodule

// File: rtl/cfg_edge_sync.sv
module cfg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic a_clk,
  input  logic a_dat,
  output logic rise,
  output logic dat_s
);
  logic [STAGES-1:0] c_sh;
  logic [STAGES-1:0] d_sh;
  logic              c_last;

  always_ff @(posedge clk) begin
    c_sh   <= {c_sh[STAGES-2:0], a_clk};
    d_sh   <= {d_sh[STAGES-2:0], a_dat};
    c_last <= c_sh[STAGES-1];
  end

  assign rise  = c_sh[STAGES-1] & ~c_last;
  assign dat_s = d_sh[STAGES-1];
endmodule

// File: rtl/cfg_shift_chain.sv
module cfg_shift_chain #(
  parameter int LEN = 18,
  localparam int CW = $clog2(LEN + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en,
  input  logic           bit_in,
  output logic [LEN-1:0] chain_q,
  output logic [CW-1:0]  cnt_q,
  output logic           full
);
  assign full = (cnt_q == CW'(LEN));

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      cnt_q   <= '0;
    end else if (shift_en && !full) begin
      chain_q <= {chain_q[LEN-2:0], bit_in};
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  // R6/R7: the count never passes the chain length
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(LEN));
  // R6/R7: once full, further bits leave the chain untouched
  p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    full |=> $stable(chain_q) && $stable(cnt_q));
endmodule

// File: rtl/cfg_strap_loader.sv
module cfg_strap_loader
  import cfg_pkg::*;
#(
  parameter bit WITH_DDSK   = 1'b0,
  parameter int ROM_DEPTH   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int LEN = 18 + int'(WITH_DDSK),
  localparam int CW  = $clog2(LEN + 1),
  localparam int AW  = $clog2(ROM_DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] strap_mode,
  input  logic       sel_msb,
  input  logic       ser_clk,
  input  logic       ser_dat,
  input  logic       ee_bit_vld,
  input  logic       ee_bit,
  output logic       ee_start,
  output logic [6:0] fb_div,
  output logic [1:0] out_range,
  output logic       ref_cascade,
  output logic       ref_diff,
  output logic       pll_bypass,
  output logic [5:0] ref_div,
  output logic       deskew_off,
  output logic       cfg_done
);
  logic            rst;
  src_e            mode_q;
  logic [AW-1:0]   addr_q;
  logic            primed;
  logic            loaded;
  logic            done_q;
  logic            ee_start_q;
  cfg_fields_t     fields_q;
  logic [MAXW-1:0] rom_q;
  logic            edge_rise;
  logic            dat_s;
  logic [LEN-1:0]  chain_q;
  logic [CW-1:0]   cnt_q;
  logic [CW-1:0]   rom_idx;
  logic            full;
  logic            sh_en;
  logic            sh_bit;

  assign rst = ~rst_n;

  cfg_rom #(.DEPTH(ROM_DEPTH), .DDSK_EN(WITH_DDSK)) u_rom (
    .clk(clk), .addr(addr_q), .word_q(rom_q)
  );

  cfg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .a_clk(ser_clk), .a_dat(ser_dat), .rise(edge_rise), .dat_s(dat_s)
  );

  // table word is sent top bit first so its first bit lands at the far end
  assign rom_idx = CW'(LEN - 1) - cnt_q;

  always_comb begin
    case (mode_q)
      SRC_DIRECT: begin sh_en = edge_rise;  sh_bit = dat_s;  end
      SRC_EEPROM: begin sh_en = ee_bit_vld; sh_bit = ee_bit; end
      default: begin
        sh_en  = primed;
        sh_bit = full ? 1'b0 : rom_q[rom_idx];
      end
    endcase
  end

  cfg_shift_chain #(.LEN(LEN)) u_chain (
    .clk(clk), .rst(rst), .shift_en(sh_en), .bit_in(sh_bit),
    .chain_q(chain_q), .cnt_q(cnt_q), .full(full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= src_e'(strap_mode);
      addr_q     <= AW'({sel_msb, ser_clk, ser_dat});
      primed     <= 1'b0;
      loaded     <= 1'b0;
      done_q     <= 1'b0;
      ee_start_q <= 1'b0;
      fields_q   <= '0;
    end else begin
      primed     <= 1'b1;
      ee_start_q <= !primed && (mode_q == SRC_EEPROM);
      done_q     <= 1'b0;
      if (full && !loaded) begin
        loaded   <= 1'b1;
        done_q   <= 1'b1;
        fields_q <= unpack_chain(MAXW'(chain_q), WITH_DDSK);
      end
    end
  end

  assign ee_start    = ee_start_q;
  assign cfg_done    = done_q;
  assign fb_div      = fields_q.n;
  assign out_range   = fields_q.r;
  assign ref_cascade = fields_q.cm;
  assign ref_diff    = fields_q.cs;
  assign pll_bypass  = fields_q.test;
  assign ref_div     = fields_q.m;
  assign deskew_off  = fields_q.ddsk;

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_done |=> !cfg_done);
  // R8: fields frozen once loaded
  p_fields_hold_r8: assert property (@(posedge clk) disable iff (rst)
    loaded |=> $stable(fields_q));
  // R8: fields stay clear before completion
  p_fields_clear_r8: assert property (@(posedge clk) disable iff (rst)
    !loaded |-> fields_q == '0);
  // R7: reader start only in EEPROM mode
  p_ee_mode_r7: assert property (@(posedge clk) disable iff (rst)
    ee_start |-> mode_q == SRC_EEPROM);
  // R2: source fixed after reset
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
    primed |-> $stable(mode_q));
endmodule

// File: tb/cfg_strap_loader_test.sv
module cfg_strap_loader_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] strap_mode = 2'b00;
  logic       sel_msb = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
  logic       ee_bit_vld = 1'b0, ee_bit = 1'b0;
  logic       ee_start, ref_cascade, ref_diff, pll_bypass, deskew_off, cfg_done;
  logic [6:0] fb_div;
  logic [1:0] out_range;
  logic [5:0] ref_div;

  int checks = 0, fails = 0, done_seen = 0, ee_seen = 0;

  always #10 clk = ~clk;

  cfg_strap_loader uut (
    .clk(clk), .rst_n(rst_n), .strap_mode(strap_mode), .sel_msb(sel_msb),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ee_bit_vld(ee_bit_vld), .ee_bit(ee_bit),
    .ee_start(ee_start), .fb_div(fb_div), .out_range(out_range),
    .ref_cascade(ref_cascade), .ref_diff(ref_diff), .pll_bypass(pll_bypass),
    .ref_div(ref_div), .deskew_off(deskew_off), .cfg_done(cfg_done)
  );

  always @(negedge clk) begin
    if (rst_n && cfg_done) done_seen++;
    if (rst_n && ee_start) ee_seen++;
  end

  function automatic logic [17:0] pk(input logic [6:0] n, input logic [1:0] r,
      input logic cm, input logic cs, input logic t, input logic [5:0] m);
    return {m, t, cs, cm, r, n};
  endfunction

  function automatic logic [17:0] got();
    return {ref_div, pll_bypass, ref_diff, ref_cascade, out_range, fb_div};
  endfunction

  function automatic logic [17:0] exp_rom(input int code);
    case (code)
      0: return pk(7'd0, 2'b01, 1, 1, 0, 6'd0);
      1: return pk(7'd2, 2'b10, 1, 1, 0, 6'd5);
      2: return pk(7'd5, 2'b01, 1, 1, 0, 6'd2);
      3: return pk(7'd0, 2'b01, 0, 1, 0, 6'd0);
      4: return pk(7'd0, 2'b01, 0, 0, 0, 6'd0);
      5: return pk(7'd2, 2'b10, 0, 0, 0, 6'd5);
      6: return pk(7'd5, 2'b01, 0, 0, 0, 6'd2);
      default: return pk(7'd0, 2'b00, 0, 0, 1, 6'd0);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic reset_into(input logic [1:0] strap, input logic [2:0] pins, input string tag);
    @(negedge clk);
    rst_n = 1'b0; strap_mode = strap;
    {sel_msb, ser_clk, ser_dat} = pins;
    ee_bit_vld = 1'b0;
    repeat (5) @(negedge clk);
    chk(got() == 18'd0 && !deskew_off, tag, "fields in reset", 32'(got()), 0);
    chk(!cfg_done && !ee_start, tag, "done/start in reset", {cfg_done, ee_start}, 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!cfg_done && k < 200);
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b; ser_clk = 1'b0;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    repeat (3) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic t_rom(input int code, input logic [1:0] strap);
    int k, d0;
    logic [17:0] e;
    e = exp_rom(code);
    reset_into(strap, 3'(code), "R1");
    strap_mode = 2'b01;            // R2: later strap change ignored
    d0 = done_seen;
    wait_done(k);
    chk(k == 20, "R5", "table load latency", k, 20);
    chk(got() == e, "R4", $sformatf("table code %0d", code), 32'(got()), 32'(e));
    chk(deskew_off == 1'b0, "R3", "deskew field absent", deskew_off, 0);
    repeat (6) begin
      ser_clk = ~ser_clk; sel_msb = ~sel_msb;
      repeat (4) @(negedge clk);
    end
    chk(got() == e, "R8", "fields stable after load", 32'(got()), 32'(e));
    chk(done_seen - d0 == 1, "R8", "single done pulse", done_seen - d0, 1);
    chk(ee_seen == 0 || strap == 2'b10, "R7", "no reader start in table mode", ee_seen, 0);
  endtask

  task automatic t_direct();
    logic [17:0] w;
    int d0, e0;
    w = pk(7'h5A, 2'b11, 1, 0, 1, 6'h2B);
    reset_into(2'b01, 3'b001, "R1");
    d0 = done_seen; e0 = ee_seen;
    for (int i = 17; i > 0; i--) send_bit(w[i]);
    repeat (6) @(negedge clk);
    chk(got() == 18'd0, "R8", "fields clear before last bit", 32'(got()), 0);
    send_bit(w[0]);
    repeat (10) @(negedge clk);
    chk(got() == w, "R6", "direct word", 32'(got()), 32'(w));
    chk(got() == w, "R3", "chain order first->ref_div5", 32'(got()), 32'(w));
    chk(done_seen - d0 == 1, "R6", "done after 18 edges", done_seen - d0, 1);
    for (int i = 0; i < 4; i++) send_bit(~w[i]);
    repeat (10) @(negedge clk);
    chk(got() == w, "R6", "extra edges ignored", 32'(got()), 32'(w));
    chk(done_seen - d0 == 1, "R6", "no second done", done_seen - d0, 1);
    chk(ee_seen == e0, "R7", "no reader start in direct mode", ee_seen - e0, 0);
  endtask

  task automatic t_eeprom();
    logic [17:0] w;
    int d0, e0;
    w = pk(7'h11, 2'b01, 0, 1, 0, 6'h3E);
    reset_into(2'b10, 3'b000, "R1");
    d0 = done_seen; e0 = ee_seen;
    @(negedge clk);
    chk(ee_start == 1'b1, "R7", "reader start first cycle", ee_start, 1);
    @(negedge clk);
    chk(ee_start == 1'b0, "R7", "reader start ends", ee_start, 0);
    for (int i = 17; i >= 0; i--) begin
      ee_bit = w[i]; ee_bit_vld = 1'b1;
      @(negedge clk);
      ee_bit_vld = 1'b0;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(got() == w, "R7", "reader word", 32'(got()), 32'(w));
    for (int i = 0; i < 3; i++) begin
      ee_bit = ~w[i]; ee_bit_vld = 1'b1;
      @(negedge clk);
    end
    ee_bit_vld = 1'b0;
    repeat (4) @(negedge clk);
    chk(got() == w, "R7", "extra reader bits ignored", 32'(got()), 32'(w));
    chk(done_seen - d0 == 1, "R8", "one done in reader mode", done_seen - d0, 1);
    chk(ee_seen - e0 == 1, "R7", "one start pulse", ee_seen - e0, 1);
  endtask

  task automatic t_rereset();
    int k;
    reset_into(2'b00, 3'd6, "R9");   // previous load cleared
    wait_done(k);
    chk(got() == exp_rom(6), "R9", "reload after reset", 32'(got()), 32'(exp_rom(6)));
    reset_into(2'b01, 3'b001, "R9");
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    reset_into(2'b00, 3'd3, "R9");   // partial bits discarded
    wait_done(k);
    chk(k == 20, "R9", "fresh load latency", k, 20);
    chk(got() == exp_rom(3), "R9", "fresh load word", 32'(got()), 32'(exp_rom(3)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 8; c++) t_rom(c, 2'b00);
    t_rom(5, 2'b11);                 // R2: alternate table strap
    t_direct();
    t_eeprom();
    t_rereset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule